// File: doc/BRIEF.md
# Interrupt Pending/Enable Registers and Priority Selector

This block keeps the per-hart interrupt-pending and interrupt-enable state. It has a machine view of sixteen bits and a supervisor view of the same storage. On every cycle it picks the most urgent interrupt that is both pending and enabled. The pick is made once for the machine target and once for the supervisor target. A delegation mask decides which target each interrupt belongs to.

Some pending bits are copies of the incoming machine external, machine timer, machine software and supervisor timer lines, taken each cycle. Two pending bits are set by hardware and cleared by software: the supervisor external bit and the supervisor software bit. A third such bit is the local counter-overflow bit at position 13. It is raised whenever any flag in a vector of counter overflow flags goes from 0 to 1. Writes and reads reach the registers through a small port with a two-bit register select. Each of the two targets gets a registered take request and a cause code, one cycle after the winning candidate appears.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous reset, all four register views read 0x0000, and both take outputs and both cause outputs are 0.
- R2: Pending bits 11, 7, 3 and 5 hold the values of the machine external, machine timer, machine software and supervisor timer lines, sampled at the previous edge. Writes through the register port do not change these four bits.
- R3: Bits 0, 2, 4, 6, 8, 10, 12, 14 and 15 of the pending and enable registers always read zero. Writing ones to them has no effect: writing 0xFFFF to the machine pending view (select 0) reads back 0x2202, and to the machine enable view (select 1) reads back 0x2AAA.
- R4: Pending bit 1 is set by a one-cycle pulse on `sw_s_set_i`. Pending bit 9 is set in every cycle where `ext_s_i` is high. Both bits stay set until software writes them to 0 through the machine pending view.
- R5: Pending bit 13 is set at the edge after any overflow flag rises from 0 to 1, and it stays set until software clears it. A flag that stays high does not set the bit again after it is cleared. A different flag rising later does set it again.
- R6: When hardware sets a pending bit (1, 9 or 13) in the same cycle that software writes it to 0, the bit ends up set.
- R7: Every implemented enable bit (1, 3, 5, 7, 9, 11, 13) can be written and read back through the machine enable view.
- R8: Delegation applies only to bits 1, 5, 9 and 13. The supervisor pending view (select 2) and supervisor enable view (select 3) show the stored bits ANDed with this effective mask. A write through select 2 changes only bits 1 and 13, and only where they are delegated. A write through select 3 changes only delegated bits.
- R9: The machine selector considers pending, enabled and undelegated bits. It serves them in this order, with these causes: 11, 3, 7, 9, 1, 5, 13. Each cause equals the bit index.
- R10: The supervisor selector considers pending, enabled and delegated bits. It serves them in the order 9, 1, 5, 13.
- R11: A take output rises at the second edge after its input line changes: one edge to set the pending bit, one for the output register. When a selector has no candidate, its take output is 0 and its cause output is 0.
- R12: With `HAS_LCOF` = 0, bit 13 of both pending and enable is read-only zero. Overflow flags then have no effect, and writing 0xFFFF reads back 0x0202 (pending) and 0x0AAA (enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_m_i | input | 1 | Machine external interrupt line |
| tmr_m_i | input | 1 | Machine timer interrupt line |
| sw_m_i | input | 1 | Machine software interrupt line |
| ext_s_i | input | 1 | Supervisor external request; sets pending bit 9 |
| tmr_s_i | input | 1 | Supervisor timer interrupt line |
| sw_s_set_i | input | 1 | Controller pulse that sets pending bit 1 |
| ovf_flags_i | input | NCNT | Per-counter overflow flags |
| deleg_i | input | 16 | Delegation mask; a set bit routes to supervisor |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | 0 machine pending, 1 machine enable, 2 supervisor pending, 3 supervisor enable |
| csr_wdata_i | input | 16 | Write data |
| csr_rdata_o | output | 16 | Read data of the selected view |
| take_m_o | output | 1 | Registered machine interrupt request |
| cause_m_o | output | 4 | Bit index of the machine winner |
| take_s_o | output | 1 | Registered supervisor interrupt request |
| cause_s_o | output | 4 | Bit index of the supervisor winner |

## Verification
Some faults corrupt the stored state: a lost overflow edge, a software clear that overrides a hardware set, or a reserved bit that becomes writable. These show on the read port at the negedge after the edge that caused them. A fault in the selector, such as a swapped priority or wrong routing across the delegation mask, shows on the take and cause outputs two edges after the stimulus changes. The tests remove candidates one at a time, so each neighbouring pair in both priority orders is compared directly.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int IRQ_W   = 16;
  localparam int CAUSE_W = 4;
  localparam int PRIO_N  = 7;

  localparam int B_SSI = 1;
  localparam int B_MSI = 3;
  localparam int B_STI = 5;
  localparam int B_MTI = 7;
  localparam int B_SEI = 9;
  localparam int B_MEI = 11;
  localparam int B_LCO = 13;

  localparam logic [IRQ_W-1:0] BASE_IMPL_M = 16'h0AAA;
  localparam logic [IRQ_W-1:0] LINE_M      = 16'h08A8;
  localparam logic [IRQ_W-1:0] MSW_BASE_M  = 16'h0202;
  localparam logic [IRQ_W-1:0] SSW_BASE_M  = 16'h0002;
  localparam logic [IRQ_W-1:0] SDELEG_BASE = 16'h0222;
  localparam logic [IRQ_W-1:0] LCO_M       = 16'h2000;

  localparam logic [1:0] SEL_MPEND = 2'd0;
  localparam logic [1:0] SEL_MEN   = 2'd1;
  localparam logic [1:0] SEL_SPEND = 2'd2;
  localparam logic [1:0] SEL_SEN   = 2'd3;

  // rank 0 is the most urgent
  function automatic int prio_bit(int rank);
    case (rank)
      0:       return B_MEI;
      1:       return B_MSI;
      2:       return B_MTI;
      3:       return B_SEI;
      4:       return B_SSI;
      5:       return B_STI;
      default: return B_LCO;
    endcase
  endfunction
endpackage

// File: rtl/irq_ovf_edge.sv
module irq_ovf_edge #(
  parameter int NCNT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCNT-1:0] flags_i,
  output logic            rise_o
);
  logic [NCNT-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= flags_i;
  end

  assign rise_o = |(flags_i & ~prev_q);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_hub_pkg::*;
#(
  parameter bit HAS_LCOF = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_m_i,
  input  logic             tmr_m_i,
  input  logic             sw_m_i,
  input  logic             ext_s_i,
  input  logic             tmr_s_i,
  input  logic             sw_s_set_i,
  input  logic             ovf_rise_i,
  input  logic [IRQ_W-1:0] deleg_eff_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] pend_o,
  output logic [IRQ_W-1:0] en_o
);
  localparam logic [IRQ_W-1:0] LC    = HAS_LCOF ? LCO_M : '0;
  localparam logic [IRQ_W-1:0] IMPL  = BASE_IMPL_M | LC;
  localparam logic [IRQ_W-1:0] MSW   = MSW_BASE_M | LC;
  localparam logic [IRQ_W-1:0] SSW   = SSW_BASE_M | LC;

  logic [IRQ_W-1:0] pend_q, en_q;
  logic [IRQ_W-1:0] line_vec, set_vec, pw_mask, ew_mask, sw_next;

  always_comb begin
    line_vec        = '0;
    line_vec[B_MEI] = ext_m_i;
    line_vec[B_MTI] = tmr_m_i;
    line_vec[B_MSI] = sw_m_i;
    line_vec[B_STI] = tmr_s_i;
    set_vec         = '0;
    set_vec[B_SSI]  = sw_s_set_i;
    set_vec[B_SEI]  = ext_s_i;
    set_vec[B_LCO]  = ovf_rise_i & HAS_LCOF;
  end

  always_comb begin
    pw_mask = '0;
    ew_mask = '0;
    if (we_i) begin
      case (sel_i)
        SEL_MPEND: pw_mask = MSW;
        SEL_SPEND: pw_mask = SSW & deleg_eff_i;
        SEL_MEN:   ew_mask = IMPL;
        default:   ew_mask = IMPL & deleg_eff_i;
      endcase
    end
    // hardware set is applied after the software write so it wins
    sw_next = ((pend_q & ~pw_mask) | (wdata_i & pw_mask) | set_vec) & MSW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= sw_next | (line_vec & LINE_M);
      en_q   <= (en_q & ~ew_mask) | (wdata_i & ew_mask);
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_hub_pkg::*;
(
  input  logic [IRQ_W-1:0]   cand_i,
  output logic               found_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    found_o = 1'b0;
    cause_o = '0;
    // walk from least to most urgent; the last hit is the winner
    for (int k = PRIO_N - 1; k >= 0; k--) begin
      if (cand_i[prio_bit(k)]) begin
        found_o = 1'b1;
        cause_o = CAUSE_W'(prio_bit(k));
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NCNT     = 8,
  parameter bit HAS_LCOF = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_m_i,
  input  logic               tmr_m_i,
  input  logic               sw_m_i,
  input  logic               ext_s_i,
  input  logic               tmr_s_i,
  input  logic               sw_s_set_i,
  input  logic [NCNT-1:0]    ovf_flags_i,
  input  logic [IRQ_W-1:0]   deleg_i,
  input  logic               csr_we_i,
  input  logic [1:0]         csr_sel_i,
  input  logic [IRQ_W-1:0]   csr_wdata_i,
  output logic [IRQ_W-1:0]   csr_rdata_o,
  output logic               take_m_o,
  output logic [CAUSE_W-1:0] cause_m_o,
  output logic               take_s_o,
  output logic [CAUSE_W-1:0] cause_s_o
);
  localparam logic [IRQ_W-1:0] DELEG_OK = SDELEG_BASE | (HAS_LCOF ? LCO_M : '0);

  logic               ovf_rise;
  logic [IRQ_W-1:0]   pend_q, en_q, deleg_eff, act, cand_m, cand_s;
  logic               hit_m, hit_s;
  logic [CAUSE_W-1:0] pick_m, pick_s;

  assign deleg_eff = deleg_i & DELEG_OK;

  irq_ovf_edge #(.NCNT(NCNT)) u_edge (
    .clk(clk), .rst(rst), .flags_i(ovf_flags_i), .rise_o(ovf_rise)
  );

  irq_regs #(.HAS_LCOF(HAS_LCOF)) u_regs (
    .clk(clk), .rst(rst),
    .ext_m_i(ext_m_i), .tmr_m_i(tmr_m_i), .sw_m_i(sw_m_i),
    .ext_s_i(ext_s_i), .tmr_s_i(tmr_s_i), .sw_s_set_i(sw_s_set_i),
    .ovf_rise_i(ovf_rise), .deleg_eff_i(deleg_eff),
    .we_i(csr_we_i), .sel_i(csr_sel_i), .wdata_i(csr_wdata_i),
    .pend_o(pend_q), .en_o(en_q)
  );

  assign act    = pend_q & en_q;
  assign cand_m = act & ~deleg_eff;
  assign cand_s = act & deleg_eff;

  irq_pick u_pick_m (.cand_i(cand_m), .found_o(hit_m), .cause_o(pick_m));
  irq_pick u_pick_s (.cand_i(cand_s), .found_o(hit_s), .cause_o(pick_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      take_m_o  <= 1'b0;
      cause_m_o <= '0;
      take_s_o  <= 1'b0;
      cause_s_o <= '0;
    end else begin
      take_m_o  <= hit_m;
      cause_m_o <= pick_m;
      take_s_o  <= hit_s;
      cause_s_o <= pick_s;
    end
  end

  always_comb begin
    case (csr_sel_i)
      SEL_MPEND: csr_rdata_o = pend_q;
      SEL_MEN:   csr_rdata_o = en_q;
      SEL_SPEND: csr_rdata_o = pend_q & deleg_eff;
      default:   csr_rdata_o = en_q & deleg_eff;
    endcase
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int NCNT     = 8,
  parameter bit HAS_LCOF = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [NCNT-1:0]    ovf,
  input logic [IRQ_W-1:0]   pend,
  input logic [IRQ_W-1:0]   en,
  input logic [IRQ_W-1:0]   dlg,
  input logic               take_m,
  input logic [CAUSE_W-1:0] cause_m,
  input logic               take_s,
  input logic [CAUSE_W-1:0] cause_s
);
  logic [NCNT-1:0]  prev_c;
  logic [IRQ_W-1:0] mc_q, sc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_c <= '0;
      mc_q   <= '0;
      sc_q   <= '0;
    end else begin
      prev_c <= ovf;
      mc_q   <= pend & en & ~dlg;
      sc_q   <= pend & en & dlg;
    end
  end

  a_r5_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    (HAS_LCOF && (|(ovf & ~prev_c))) |=> pend[B_LCO]);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (pend[15:14] == 2'b00) && (en[15:14] == 2'b00) && (pend[0] == 1'b0));

  a_r9_m_winner_valid: assert property (@(posedge clk) disable iff (rst)
    take_m |-> mc_q[cause_m]);

  a_r9_m_top: assert property (@(posedge clk) disable iff (rst)
    mc_q[B_MEI] |-> (take_m && cause_m == CAUSE_W'(B_MEI)));

  a_r10_s_winner_valid: assert property (@(posedge clk) disable iff (rst)
    take_s |-> (sc_q[cause_s] && (cause_s == 4'd1 || cause_s == 4'd5 ||
                                  cause_s == 4'd9 || cause_s == 4'd13)));

  a_r11_m_idle: assert property (@(posedge clk) disable iff (rst)
    (mc_q == '0) |-> (!take_m && cause_m == '0));

  a_r11_s_idle: assert property (@(posedge clk) disable iff (rst)
    (sc_q == '0) |-> (!take_s && cause_s == '0));
endmodule

bind irq_hub irq_hub_chk #(.NCNT(NCNT), .HAS_LCOF(HAS_LCOF)) u_chk (
  .clk(clk), .rst(rst), .ovf(ovf_flags_i), .pend(pend_q), .en(en_q),
  .dlg(deleg_eff), .take_m(take_m_o), .cause_m(cause_m_o),
  .take_s(take_s_o), .cause_s(cause_s_o)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_m = 0, tmr_m = 0, sw_m = 0, ext_s = 0, tmr_s = 0, sw_s_set = 0;
  logic [7:0]  ovf = '0;
  logic [15:0] deleg = '0;
  logic        we = 0;
  logic [1:0]  sel = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata_nl;
  logic        take_m, take_s, take_m_nl, take_s_nl;
  logic [3:0]  cause_m, cause_s, cause_m_nl, cause_s_nl;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_hub #(.NCNT(8), .HAS_LCOF(1'b1)) uut (
    .clk(clk), .rst(rst), .ext_m_i(ext_m), .tmr_m_i(tmr_m), .sw_m_i(sw_m),
    .ext_s_i(ext_s), .tmr_s_i(tmr_s), .sw_s_set_i(sw_s_set),
    .ovf_flags_i(ovf), .deleg_i(deleg), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .take_m_o(take_m), .cause_m_o(cause_m), .take_s_o(take_s), .cause_s_o(cause_s)
  );

  irq_hub #(.NCNT(8), .HAS_LCOF(1'b0)) uut_nl (
    .clk(clk), .rst(rst), .ext_m_i(ext_m), .tmr_m_i(tmr_m), .sw_m_i(sw_m),
    .ext_s_i(ext_s), .tmr_s_i(tmr_s), .sw_s_set_i(sw_s_set),
    .ovf_flags_i(ovf), .deleg_i(deleg), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata_nl),
    .take_m_o(take_m_nl), .cause_m_o(cause_m_nl), .take_s_o(take_s_nl), .cause_s_o(cause_s_nl)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    we = 1; sel = s; wdata = d;
    tick();
    we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    sel = s;
    #1;
    d = rdata;
  endtask

  task automatic expect_m(input string req, input logic t, input int c);
    check({req, " take_m"}, int'(take_m), int'(t));
    check({req, " cause_m"}, int'(cause_m), c);
  endtask

  task automatic expect_s(input string req, input logic t, input int c);
    check({req, " take_s"}, int'(take_s), int'(t));
    check({req, " cause_s"}, int'(cause_s), c);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      check("R1 view after reset", int'(d), 0);
    end
    expect_m("R1", 0, 0);
    expect_s("R1", 0, 0);
  endtask

  task automatic t_lines();
    logic [15:0] d;
    ext_m = 1; tmr_m = 1; sw_m = 1; tmr_s = 1;
    tick();
    rd(2'd0, d);
    check("R2 lines mirrored", int'(d), 'h08A8);
    wr(2'd0, 16'h0000);
    rd(2'd0, d);
    check("R2 write ignored on line bits", int'(d), 'h08A8);
    ext_m = 0; tmr_m = 0; sw_m = 0; tmr_s = 0;
    tick();
    rd(2'd0, d);
    check("R2 lines dropped", int'(d), 0);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d);
    check("R3 pending reserved zero", int'(d), 'h2202);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d);
    check("R3 enable reserved zero", int'(d), 'h2AAA);
    wr(2'd1, 16'h0022);
    rd(2'd1, d);
    check("R7 enable partial write", int'(d), 'h0022);
    wr(2'd1, 16'h2888);
    rd(2'd1, d);
    check("R7 enable other bits", int'(d), 'h2888);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_swbits();
    logic [15:0] d;
    sw_s_set = 1;
    tick();
    sw_s_set = 0;
    tick();
    rd(2'd0, d);
    check("R4 pulse sets bit1 and holds", int'(d), 'h0002);
    ext_s = 1;
    tick();
    ext_s = 0;
    tick();
    rd(2'd0, d);
    check("R4 ext_s sets bit9 and holds", int'(d), 'h0202);
    wr(2'd0, 16'h0000);
    rd(2'd0, d);
    check("R4 software clear", int'(d), 0);
  endtask

  task automatic t_ovf();
    logic [15:0] d;
    ovf = 8'h04;
    tick();
    rd(2'd0, d);
    check("R5 rising flag sets bit13", int'(d), 'h2000);
    wr(2'd0, 16'h0000);
    tick();
    rd(2'd0, d);
    check("R5 held flag no re-set", int'(d), 0);
    ovf = 8'h0C;
    tick();
    rd(2'd0, d);
    check("R5 new flag rise sets again", int'(d), 'h2000);
    wr(2'd0, 16'h0000);
    ovf = 8'h00;
    tick();
  endtask

  task automatic t_collide();
    logic [15:0] d;
    ovf = 8'h01; sw_s_set = 1;
    wr(2'd0, 16'h0000);
    ovf = 8'h00; sw_s_set = 0;
    rd(2'd0, d);
    check("R6 hardware set beats clear", int'(d), 'h2002);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_deleg();
    logic [15:0] d;
    deleg = 16'hFFFF;
    wr(2'd3, 16'hFFFF);
    rd(2'd1, d);
    check("R8 sie write only delegated", int'(d), 'h2222);
    rd(2'd3, d);
    check("R8 sie view", int'(d), 'h2222);
    ext_m = 1; sw_s_set = 1;
    tick();
    sw_s_set = 0;
    rd(2'd2, d);
    check("R8 sip masks machine bits", int'(d), 'h0002);
    wr(2'd2, 16'hFFFF);
    rd(2'd0, d);
    check("R8 sip write bits 1 and 13 only", int'(d), 'h2802);
    deleg = 16'h0000;
    #1;
    rd(2'd2, d);
    check("R8 sip empty without delegation", int'(d), 0);
    wr(2'd2, 16'h0000);
    rd(2'd0, d);
    check("R8 undelegated sip write ignored", int'(d), 'h2802);
    ext_m = 0;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_mprio();
    wr(2'd1, 16'h2AAA);
    ext_m = 1; sw_m = 1; tmr_m = 1; ext_s = 1; tmr_s = 1;
    wr(2'd0, 16'h2202);
    tick();
    expect_m("R9 all pending", 1, 11);
    ext_m = 0; tick(); tick();
    expect_m("R9 after MEI", 1, 3);
    sw_m = 0; tick(); tick();
    expect_m("R9 after MSI", 1, 7);
    tmr_m = 0; tick(); tick();
    expect_m("R9 after MTI", 1, 9);
    ext_s = 0;
    wr(2'd0, 16'h2002); tick();
    expect_m("R9 after SEI", 1, 1);
    wr(2'd0, 16'h2000); tick();
    expect_m("R9 after SSI", 1, 5);
    tmr_s = 0; tick(); tick();
    expect_m("R9 after STI", 1, 13);
    wr(2'd0, 16'h0000); tick();
    expect_m("R11 none pending", 0, 0);
    expect_s("R9 nothing delegated", 0, 0);
  endtask

  task automatic t_sprio();
    deleg = 16'hFFFF;
    ext_m = 1; ext_s = 1; tmr_s = 1;
    wr(2'd0, 16'h2002);
    tick();
    expect_m("R10 machine keeps MEI", 1, 11);
    expect_s("R10 all S pending", 1, 9);
    ext_s = 0;
    wr(2'd0, 16'h2002); tick();
    expect_s("R10 after SEI", 1, 1);
    wr(2'd0, 16'h2000); tick();
    expect_s("R10 after SSI", 1, 5);
    tmr_s = 0; tick(); tick();
    expect_s("R10 after STI", 1, 13);
    wr(2'd0, 16'h0000); tick();
    expect_s("R10 empty", 0, 0);
    expect_m("R10 machine unaffected", 1, 11);
    ext_m = 0; deleg = '0;
    tick(); tick();
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_timing();
    wr(2'd1, 16'h0080);
    tmr_m = 1;
    tick();
    expect_m("R11 one edge not yet", 0, 0);
    tick();
    expect_m("R11 second edge", 1, 7);
    tmr_m = 0;
    tick(); tick();
    expect_m("R11 drop", 0, 0);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_nolcof();
    ovf = 8'h80;
    tick();
    sel = 2'd0; #1;
    check("R12 overflow ignored", int'(rdata_nl), 0);
    ovf = 8'h00;
    wr(2'd0, 16'hFFFF);
    sel = 2'd0; #1;
    check("R12 pending mask", int'(rdata_nl), 'h0202);
    wr(2'd1, 16'hFFFF);
    sel = 2'd1; #1;
    check("R12 enable mask", int'(rdata_nl), 'h0AAA);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1;
    tick(); tick();
    rst = 0;
    #1;
    t_reset();
    t_lines();
    t_reserved();
    t_swbits();
    t_ovf();
    t_collide();
    t_deleg();
    t_mprio();
    t_sprio();
    t_timing();
    t_nolcof();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule